// File: doc/BRIEF.md
# Phase-Correct PWM Timer/Counter

This block is a synchronous timer/counter that produces a symmetric pulse-width-modulated waveform. A counter runs up from zero to a TOP value and back down to zero, and a compare value is checked against it on both slopes. Crossing the compare value on the way up drives the output one way. Crossing it on the way down drives it the other way. Because each pulse is centred on TOP, the pulse centres stay fixed in phase as the duty cycle changes.

The counter advances only on ticks from a prescaler, which divides the system clock by 1, 8, 64, 256 or 1024. The prescaler acts as a clock enable. The counter does not run on a derived clock. Software writes the compare value into a buffer. The buffer moves into the active compare register at TOP in phase-correct mode and at BOTTOM in phase-and-frequency-correct mode. TOP comes either from a separate TOP register or from the active compare value. The second choice, together with the toggle output mode, gives a square wave with 50% duty.

A sticky flag records each compare match, and a clear pulse resets it. The output can be disconnected, toggled, non-inverted or inverted.

Top module: `pwm_timer`

## Requirements
- R1: The clock select `clk_sel` encodes 0 = stopped, 1 = divide by 1, 2 = by 8, 3 = by 64, 4 = by 256, 5 = by 1024, and 6 and 7 = stopped. When the timer starts from the stopped state, the counter reaches k after exactly k·N system clock edges.
- R2: While `clk_sel` selects stopped, `count` and `wave_out` keep their values.
- R3: With TOP ≥ 1, the counter runs 0,1,…,TOP,TOP−1,…,1,0,1,… and turns at each end without repeating the end value. A full period is 2·TOP ticks. `wave_mode` bit 0 selects the source of TOP: 0 takes it from the TOP register and 1 takes it from the active compare value.
- R4: In non-inverted mode (`out_mode` = 2) with 0 < C < TOP, the output goes low on the tick where the counter equals C while counting up. It goes high on the tick where the counter equals C while counting down. It is high for 2·C of every 2·TOP ticks.
- R5: In non-inverted mode, a compare value of 0 holds the output low. A compare value at or above TOP holds it high.
- R6: `out_mode` encodes 0 = output held low, 1 = toggle, 2 = non-inverted, 3 = inverted. In inverted mode the output is the complement of the non-inverted waveform, which makes it high for 2·(TOP − min(C,TOP)) of every 2·TOP ticks.
- R7: In toggle mode with TOP taken from the compare value C, the output inverts once per counter period. The result is a period of 4·C ticks with 2·C high. In toggle mode with TOP taken from the TOP register, the output stays low.
- R8: When `wave_mode` bit 1 is 0 (phase-correct), a compare write goes to a buffer. The buffer is copied to the active compare value on the tick where the counter is at TOP.
- R9: When `wave_mode` bit 1 is 1 (phase-and-frequency-correct), the buffer is copied to the active compare value on the tick where the counter is at zero.
- R10: `match_flag` rises one tick after the counter equals the active compare value. At that point the counter has already moved one step past the match.
- R11: `match_flag` stays set until `flag_clr` is asserted. If a clear and a new match fall in the same cycle, the flag ends up set.
- R12: After reset the counter is 0 and counting up, `wave_out` and `match_flag` are 0, the compare buffer and the active compare value are 0, and the TOP register is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Prescaler selection |
| wave_mode | input | 2 | Bit 0: TOP from compare; bit 1: load buffer at zero |
| out_mode | input | 2 | Output behaviour selection |
| cmp_we | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | CNT_W | Compare value to buffer |
| top_we | input | 1 | Write strobe for the TOP register |
| top_wdata | input | CNT_W | TOP value |
| flag_clr | input | 1 | Clears the match flag |
| count | output | CNT_W | Current counter value |
| wave_out | output | 1 | Registered waveform output |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench sweeps every compare value from zero to one past TOP for several small TOP values, in both output polarities and both buffer-load variants. It counts high cycles over a whole period. A design that mishandles the extremes would produce a one-tick glitch at zero or at TOP. A design with swapped slopes would give the complementary duty. A second test writes a new compare value while the counter is climbing past the old match point, then reads the counter value at which the output next rises. Loading at the wrong end, or loading without buffering, shows up as a different counter value. Further tests check that the flag rises only after the counter has left the match value, that a clear arriving together with a match loses, and that every prescaler ratio produces the exact edge counts.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [2:0] {
    CS_STOP    = 3'd0,
    CS_DIV1    = 3'd1,
    CS_DIV8    = 3'd2,
    CS_DIV64   = 3'd3,
    CS_DIV256  = 3'd4,
    CS_DIV1024 = 3'd5,
    CS_RSV6    = 3'd6,
    CS_RSV7    = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic load_at_bottom;
    logic top_from_cmp;
  } wave_mode_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int SH_B = 3,
  parameter int SH_C = 6,
  parameter int SH_D = 8,
  parameter int SH_E = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel,
  output logic     tick
);

  localparam int PRE_W = SH_E;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             run;

  always_comb begin
    run = 1'b1;
    lim = '0;
    case (sel)
      CS_DIV1:    lim = '0;
      CS_DIV8:    lim = PRE_W'((1 << SH_B) - 1);
      CS_DIV64:   lim = PRE_W'((1 << SH_C) - 1);
      CS_DIV256:  lim = PRE_W'((1 << SH_D) - 1);
      CS_DIV1024: lim = PRE_W'((1 << SH_E) - 1);
      default:    run = 1'b0;
    endcase
  end

  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (pre_q >= lim) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  p_stop_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == CS_STOP || sel == CS_RSV6 || sel == CS_RSV7) |-> !tick);

  p_div1_every_r1: assert property (@(posedge clk) disable iff (rst)
    (sel == CS_DIV1) |-> tick);

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             at_top_o,
  output logic             at_bot_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  assign at_top_o = (cnt_q >= top_i);
  assign at_bot_o = (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign up_o     = up_q;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (tick) begin
      if (up_q) begin
        if (at_top_o) begin
          up_d = 1'b0;
          if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (at_bot_o) begin
          up_d = 1'b1;
          if (top_i != '0) cnt_d = CNT_W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && top_i != '0 && cnt_q <= top_i && $stable(top_i))
      |=> ((cnt_q - $past(cnt_q)) == CNT_W'(1) || (cnt_q - $past(cnt_q)) == '1));

  p_turn_at_top_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && up_q && top_i != '0 && cnt_q == top_i) |=> !up_q);

endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             at_top_i,
  input  logic             at_bot_i,
  input  logic [CNT_W-1:0] top_i,
  input  wave_mode_t       mode_i,
  input  out_mode_e        om_i,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pin_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] buf_q, act_q;
  logic             wave_q, wave_d;
  logic             pin_q, pin_d;
  logic             flag_q;
  logic             load_en, match;

  assign load_en   = tick && (mode_i.load_at_bottom ? at_bot_i : at_top_i);
  assign match     = tick && (cnt_i == act_q);
  assign cmp_act_o = act_q;
  assign pin_o     = pin_q;
  assign flag_o    = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (cmp_we)  buf_q <= cmp_wdata;
      if (load_en) act_q <= buf_q;
    end
  end

  always_comb begin
    wave_d = wave_q;
    if (tick) begin
      case (om_i)
        OM_TOGGLE: begin
          if (mode_i.top_from_cmp && match) wave_d = ~wave_q;
        end
        OM_NONINV, OM_INV: begin
          if (act_q == '0)         wave_d = 1'b0;
          else if (act_q >= top_i) wave_d = 1'b1;
          else if (match)          wave_d = ~up_i;
        end
        default: wave_d = wave_q;
      endcase
    end
  end

  always_comb begin
    case (om_i)
      OM_TOGGLE: pin_d = mode_i.top_from_cmp ? wave_d : 1'b0;
      OM_NONINV: pin_d = wave_d;
      OM_INV:    pin_d = ~wave_d;
      default:   pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
      pin_q  <= pin_d;
      if (match)         flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  p_act_only_at_load_r8: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(act_q));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);

  p_flag_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_i == act_q) |=> flag_q);

  p_zero_cmp_low_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && om_i == OM_NONINV && act_q == '0) |=> !pin_q);

  p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    (om_i == OM_OFF) |=> !pin_q);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SH_B  = 3,
  parameter int SH_C  = 6,
  parameter int SH_D  = 8,
  parameter int SH_E  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       wave_mode,
  input  logic [1:0]       out_mode,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             top_we,
  input  logic [CNT_W-1:0] top_wdata,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             wave_out,
  output logic             match_flag
);

  wave_mode_t       mode;
  logic             tick;
  logic [CNT_W-1:0] top_q, top_eff, cmp_act;
  logic             up, at_top, at_bot;

  assign mode    = wave_mode_t'(wave_mode);
  assign top_eff = mode.top_from_cmp ? cmp_act : top_q;

  always_ff @(posedge clk) begin
    if (rst)         top_q <= '1;
    else if (top_we) top_q <= top_wdata;
  end

  pwm_prescaler #(
    .SH_B(SH_B), .SH_C(SH_C), .SH_D(SH_D), .SH_E(SH_E)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (clk_sel_e'(clk_sel)),
    .tick (tick)
  );

  pwm_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .top_i    (top_eff),
    .cnt_o    (count),
    .up_o     (up),
    .at_top_o (at_top),
    .at_bot_o (at_bot)
  );

  pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_i     (count),
    .up_i      (up),
    .at_top_i  (at_top),
    .at_bot_i  (at_bot),
    .top_i     (top_eff),
    .mode_i    (mode),
    .om_i      (out_mode_e'(out_mode)),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .flag_clr  (flag_clr),
    .cmp_act_o (cmp_act),
    .pin_o     (wave_out),
    .flag_o    (match_flag)
  );

  p_top_write_r12: assert property (@(posedge clk) disable iff (rst)
    !top_we |=> $stable(top_q));

endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   clk_sel = '0;
  logic [1:0]   wave_mode = '0;
  logic [1:0]   out_mode = '0;
  logic         cmp_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic         top_we = 1'b0;
  logic [W-1:0] top_wdata = '0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count;
  logic         wave_out;
  logic         match_flag;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .out_mode(out_mode), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .top_we(top_we), .top_wdata(top_wdata), .flag_clr(flag_clr),
    .count(count), .wave_out(wave_out), .match_flag(match_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; clk_sel = '0; cmp_we = 1'b0; top_we = 1'b0; flag_clr = 1'b0;
    wave_mode = '0; out_mode = '0;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  task automatic wr_top(input int v);
    top_wdata = W'(v); top_we = 1'b1; step(1); top_we = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata = W'(v); cmp_we = 1'b1; step(1); cmp_we = 1'b0;
  endtask

  task automatic duty_case(input int md, input int om, input int t, input int c,
                           input int win, input int exp_hi, input string req);
    int hi;
    do_reset();
    wr_top(t);
    wr_cmp(c);
    wave_mode = 2'(md); out_mode = 2'(om); clk_sel = 3'd1;
    step(4 * t + 8);
    hi = 0;
    for (int k = 0; k < win; k++) begin
      if (wave_out) hi++;
      step(1);
    end
    chk(hi == exp_hi, req, hi, exp_hi);
  endtask

  task automatic buf_case(input int md, input int exp_cnt, input string req);
    int prev;
    do_reset();
    wr_top(10);
    wr_cmp(3);
    wave_mode = 2'(md); out_mode = 2'd2; clk_sel = 3'd1;
    step(50);
    for (int k = 0; k < 100; k++) begin
      prev = int'(count);
      step(1);
      if (count == 5 && prev == 4) break;
    end
    wr_cmp(7);
    for (int k = 0; k < 40; k++) begin
      if (wave_out) break;
      step(1);
    end
    chk(count == W'(exp_cnt), req, int'(count), exp_cnt);
  endtask

  task automatic presc_case(input int sel, input int n);
    do_reset();
    wr_top(255);
    clk_sel = 3'(sel);
    step(n - 1);
    chk(count == 0, "R1", int'(count), 0);
    step(1);
    chk(count == 1, "R1", int'(count), 1);
    step(n - 1);
    chk(count == 1, "R1", int'(count), 1);
    step(1);
    chk(count == 2, "R1", int'(count), 2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int prev, hi, edges, snap_cnt, snap_pin;
    bit lastp;

    do_reset();
    // R12: reset state
    chk(count == 0, "R12", int'(count), 0);
    chk(wave_out == 1'b0, "R12", int'(wave_out), 0);
    chk(match_flag == 1'b0, "R12", int'(match_flag), 0);

    // R3: triangle sequence, TOP = 6
    wr_top(6);
    wr_cmp(3);
    wave_mode = 2'd0; out_mode = 2'd2; clk_sel = 3'd1;
    for (int k = 0; k <= 30; k++) begin
      int p, e;
      p = k % 12;
      e = (p <= 6) ? p : 12 - p;
      chk(count == W'(e), "R3", int'(count), e);
      step(1);
    end
    // R2: stopped holds counter and output
    step(2);
    clk_sel = 3'd0;
    snap_cnt = int'(count); snap_pin = int'(wave_out);
    step(50);
    chk(count == W'(snap_cnt), "R2", int'(count), snap_cnt);
    chk(int'(wave_out) == snap_pin, "R2", int'(wave_out), snap_pin);
    clk_sel = 3'd7;
    step(20);
    chk(count == W'(snap_cnt), "R2", int'(count), snap_cnt);

    // R1: prescaler ratios
    presc_case(1, 1);
    presc_case(2, 8);
    presc_case(3, 64);
    presc_case(4, 256);
    presc_case(5, 1024);

    // R12: compare value resets to zero, so output stays low
    do_reset();
    wr_top(4);
    wave_mode = 2'd0; out_mode = 2'd2; clk_sel = 3'd1;
    step(30);
    hi = 0;
    for (int k = 0; k < 8; k++) begin if (wave_out) hi++; step(1); end
    chk(hi == 0, "R12", hi, 0);

    // R4 R5 R6: duty sweep in both buffer variants
    for (int md = 0; md <= 2; md += 2) begin
      for (int t = 1; t <= 5; t++) begin
        for (int c = 0; c <= t + 1; c++) begin
          int cm;
          cm = (c < t) ? c : t;
          duty_case(md, 2, t, c, 2 * t, 2 * cm, (c == 0 || c >= t) ? "R5" : "R4");
          duty_case(md, 3, t, c, 2 * t, 2 * t - 2 * cm, "R6");
        end
      end
    end
    // R6: output off mode stays low
    duty_case(0, 0, 4, 2, 8, 0, "R6");

    // R7: toggle with TOP from compare gives 50%
    for (int c = 1; c <= 5; c++) begin
      do_reset();
      wr_cmp(c);
      wave_mode = 2'd1; out_mode = 2'd1; clk_sel = 3'd1;
      step(4 * c + 8);
      hi = 0; edges = 0; lastp = wave_out;
      for (int k = 0; k < 4 * c; k++) begin
        if (wave_out) hi++;
        step(1);
        if (wave_out && !lastp) edges++;
        lastp = wave_out;
      end
      chk(hi == 2 * c, "R7", hi, 2 * c);
      chk(edges == 1, "R7", edges, 1);
    end
    // R7: toggle with TOP from register keeps output low
    duty_case(0, 1, 4, 2, 16, 0, "R7");

    // R8: phase-correct loads at TOP; R9: frequency-correct loads at zero
    buf_case(0, 6, "R8");
    buf_case(2, 2, "R9");

    // R10 R11: match flag
    do_reset();
    wr_top(8);
    wr_cmp(3);
    wave_mode = 2'd0; out_mode = 2'd2; clk_sel = 3'd1;
    step(40);
    for (int k = 0; k < 100; k++) begin
      prev = int'(count);
      step(1);
      if (count == 5 && prev == 4) break;
    end
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk(match_flag == 1'b0, "R11", int'(match_flag), 0);
    prev = 0;
    for (int k = 0; k < 40; k++) begin
      if (match_flag) break;
      prev = int'(count);
      step(1);
    end
    chk(prev == 3, "R10", prev, 3);
    chk(count == 2, "R10", int'(count), 2);
    step(20);
    chk(match_flag == 1'b1, "R11", int'(match_flag), 1);
    flag_clr = 1'b1;
    step(1);
    hi = 0;
    for (int k = 0; k < 16; k++) begin if (match_flag) hi++; step(1); end
    chk(hi == 2, "R11", hi, 2);
    flag_clr = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule